// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block sits between the peripheral request flags of a small processor and its instruction sequencer. Twenty-one source flags, each paired with an enable, are folded onto ten vectors. Each vector has a one-bit priority setting. Its request is ranked as low, high or top: the top rank is open only to vectors 0 and 1. A registered arbiter picks one winning vector each cycle and presents its entry address together with a request line and the winner's level.

The processor acknowledges a request with a one-cycle strobe. The block then pushes the winner's level onto a three-entry stack of levels in service. The top of that stack is the current level. A request whose level does not exceed the current level is held off until a return strobe pops the stack. Source flags belong to the peripherals and to software. The block never clears them.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A vector requests when at least one of its sources has both its pending bit and its enable bit set. A source whose enable bit is 0 has no effect.
- R2: Sources are assigned to vectors in ascending order. Vectors 0 to 9 own 1, 1, 3, 2, 1, 2, 2, 3, 3 and 3 sources, so vector 0 owns source 0 and vector 9 owns sources 18 to 20.
- R3: Level codes are 0 for none, 1 for low, 2 for high and 3 for top. When `vec_hi[v]` is 1, vectors 0 and 1 rank 3 and every other vector ranks 2. When `vec_hi[v]` is 0, the vector ranks 1.
- R4: Among the eligible vectors, the highest level wins. When levels are equal, the lowest vector index wins.
- R5: `irq_addr` is 0x03 + 8 × (winning vector index) while `irq` is 1. While `irq` is 0, both `irq_addr` and `irq_lvl` are 0.
- R6: A vector is eligible only when its level is strictly above `cur_lvl`.
- R7: `irq`, `irq_addr` and `irq_lvl` are registered. They follow the inputs one clock later. If `glb_en` was 0 at the last edge, `irq` is 0.
- R8: An `ack` sampled while `irq` is 1 pushes `irq_lvl` onto the stack. After that edge, `cur_lvl` equals the pushed level and `irq` is 0 for one cycle.
- R9: A `reti` pops the stack and `cur_lvl` returns to the previous entry, or to 0 when the stack is empty. A `reti` on an empty stack has no effect. A `reti` in the same cycle as an accepted `ack` is ignored.
- R10: An acknowledge does not clear any source. A request that is still pending wins again once `cur_lvl` drops below its level.
- R11: An `ack` sampled while `irq` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | 21 | Source pending flags |
| src_en | input | 21 | Source enable bits |
| vec_hi | input | 10 | Per-vector priority select (1 = upper rank) |
| glb_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Acknowledge strobe from the processor |
| reti | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Registered interrupt request |
| irq_addr | output | 8 | Entry address of the winning vector |
| irq_lvl | output | 2 | Level of the winning vector |
| cur_lvl | output | 2 | Level currently in service (top of stack) |

## Verification
A wrong stack entry or depth appears on `cur_lvl` in the cycle after the `ack` or `reti` that caused it. It also appears one cycle later as a wrongly accepted or wrongly withheld `irq`. A wrong source-to-vector fold, rank decode or tie-break appears on `irq_addr` and `irq_lvl` one clock after the offending input pattern. Because of this, the bench sweeps every source on its own, every ordered pair of vectors under four priority patterns, and a full nesting sequence that climbs to top level and unwinds past the empty stack.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;

  // number of sources owned by each vector
  function automatic int src_count(input int v);
    case (v)
      0: return 1;
      1: return 1;
      2: return 3;
      3: return 2;
      4: return 1;
      5: return 2;
      6: return 2;
      7: return 3;
      8: return 3;
      9: return 3;
      default: return 1;
    endcase
  endfunction

  // vector that owns source s (sources packed in ascending vector order)
  function automatic int vec_of_src(input int s);
    int acc;
    int res;
    bit hit;
    acc = 0;
    res = 0;
    hit = 1'b0;
    for (int v = 0; v < 64; v++) begin
      acc = acc + src_count(v);
      if (!hit && s < acc) begin
        res = v;
        hit = 1'b1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/irq_src_gather.sv
module irq_src_gather
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 21,
  parameter int NUM_VEC = 10
) (
  input  logic [NUM_SRC-1:0] src_pend,
  input  logic [NUM_SRC-1:0] src_en,
  output logic [NUM_VEC-1:0] vec_req
);

  logic [NUM_SRC-1:0] live;
  assign live = src_pend & src_en;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic [NUM_SRC-1:0] sel;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int OWNER = vec_of_src(s);
      if (OWNER == v) begin : g_own
        assign sel[s] = live[s];
      end else begin : g_other
        assign sel[s] = 1'b0;
      end
    end
    assign vec_req[v] = |sel;
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int NUM_VEC  = 10,
  parameter int TOP_VECS = 2,
  localparam int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] vec_req,
  input  logic [NUM_VEC-1:0] vec_hi,
  input  lvl_t               cur_lvl,
  output logic               found,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);

  lvl_t vlvl [NUM_VEC];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_rank
    if (v < TOP_VECS) begin : g_top
      assign vlvl[v] = vec_hi[v] ? LVL_TOP : LVL_LOW;
    end else begin : g_plain
      assign vlvl[v] = vec_hi[v] ? LVL_HIGH : LVL_LOW;
    end
  end

  always_comb begin
    win_lvl = LVL_NONE;
    win_idx = '0;
    // descending scan with >= leaves the lowest index on ties
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (vec_req[v] && (vlvl[v] > cur_lvl) && (vlvl[v] >= win_lvl)) begin
        win_lvl = vlvl[v];
        win_idx = IDX_W'(v);
      end
    end
    found = (win_lvl != LVL_NONE);
  end

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output lvl_t cur_lvl
);

  lvl_t          stk_q [DEPTH];
  lvl_t          stk_d [DEPTH];
  logic [DW-1:0] depth_q, depth_d;
  logic          push_ok, pop_ok, upd;

  assign push_ok = push && (depth_q < DW'(DEPTH));
  assign pop_ok  = pop && !push && (depth_q != '0);
  assign upd     = push_ok || pop_ok;

  always_comb begin
    depth_d = depth_q;
    for (int i = 0; i < DEPTH; i++) stk_d[i] = stk_q[i];
    if (push_ok) begin
      for (int i = 0; i < DEPTH; i++)
        if (DW'(i) == depth_q) stk_d[i] = push_lvl;
      depth_d = depth_q + DW'(1);
    end else if (pop_ok) begin
      depth_d = depth_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= LVL_NONE;
    end else if (upd) begin
      depth_q <= depth_d;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= stk_d[i];
    end
  end

  always_comb begin
    cur_lvl = LVL_NONE;
    for (int i = 0; i < DEPTH; i++)
      if (DW'(i + 1) == depth_q) cur_lvl = stk_q[i];
  end

  // R8
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> cur_lvl == $past(push_lvl));

  // R9
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> depth_q == $past(depth_q) - DW'(1));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && depth_q == '0) |=> cur_lvl == LVL_NONE);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC   = 21,
  parameter int NUM_VEC   = 10,
  parameter int TOP_VECS  = 2,
  parameter int ADDR_W    = 8,
  parameter int ADDR_BASE = 3,
  parameter int ADDR_STEP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pend,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_VEC-1:0] vec_hi,
  input  logic               glb_en,
  input  logic               ack,
  input  logic               reti,
  output logic               irq,
  output logic [ADDR_W-1:0]  irq_addr,
  output logic [1:0]         irq_lvl,
  output logic [1:0]         cur_lvl
);

  localparam int IDX_W     = $clog2(NUM_VEC);
  localparam int NUM_LVLS  = 3;
  localparam int TOP_LIMIT = ADDR_BASE + ADDR_STEP * TOP_VECS;

  logic [NUM_VEC-1:0] vec_req;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  lvl_t               cur_q;

  logic               irq_q, irq_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  lvl_t               lvl_q, lvl_d;

  irq_src_gather #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC)) u_gather (
    .src_pend (src_pend),
    .src_en   (src_en),
    .vec_req  (vec_req)
  );

  irq_pick #(.NUM_VEC(NUM_VEC), .TOP_VECS(TOP_VECS)) u_pick (
    .vec_req (vec_req),
    .vec_hi  (vec_hi),
    .cur_lvl (cur_q),
    .found   (found),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  irq_lvl_stack #(.DEPTH(NUM_LVLS)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack && irq_q),
    .push_lvl (lvl_q),
    .pop      (reti),
    .cur_lvl  (cur_q)
  );

  always_comb begin
    irq_d  = 1'b0;
    addr_d = '0;
    lvl_d  = LVL_NONE;
    if (!ack && glb_en && found) begin
      irq_d  = 1'b1;
      addr_d = ADDR_W'(ADDR_BASE + ADDR_STEP * int'(win_idx));
      lvl_d  = win_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      addr_q <= '0;
      lvl_q  <= LVL_NONE;
    end else begin
      irq_q  <= irq_d;
      addr_q <= addr_d;
      lvl_q  <= lvl_d;
    end
  end

  assign irq      = irq_q;
  assign irq_addr = addr_q;
  assign irq_lvl  = lvl_q;
  assign cur_lvl  = cur_q;

  // R6
  above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_lvl > cur_lvl);

  // R8
  ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);

  // R7
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !irq);

  // R3
  top_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_lvl == LVL_TOP) |-> int'(irq_addr) < TOP_LIMIT);

  // R5
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (irq_addr == '0 && irq_lvl == LVL_NONE));

  // R11
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !reti) |=> $stable(cur_lvl));

endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [20:0] src_pend, src_en;
  logic [9:0]  vec_hi;
  logic        glb_en, ack, reti;
  logic        irq;
  logic [7:0]  irq_addr;
  logic [1:0]  irq_lvl, cur_lvl;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int first_src [11] = '{0, 1, 2, 5, 7, 8, 10, 12, 15, 18, 21};
  int stk [3];
  int depth = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
    .vec_hi(vec_hi), .glb_en(glb_en), .ack(ack), .reti(reti),
    .irq(irq), .irq_addr(irq_addr), .irq_lvl(irq_lvl), .cur_lvl(cur_lvl)
  );

  function automatic int exp_cur();
    return (depth == 0) ? 0 : stk[depth-1];
  endfunction

  function automatic void model(output bit ei, output int ea, output int el);
    int best = 0;
    int bi = 0;
    for (int v = 0; v < 10; v++) begin
      bit rq = 1'b0;
      int lv;
      for (int s = first_src[v]; s < first_src[v+1]; s++)
        if (src_pend[s] && src_en[s]) rq = 1'b1;
      lv = vec_hi[v] ? ((v < 2) ? 3 : 2) : 1;
      if (rq && lv > exp_cur() && lv > best) begin
        best = lv;
        bi = v;
      end
    end
    ei = glb_en && (best != 0);
    ea = ei ? (3 + 8 * bi) : 0;
    el = ei ? best : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_out(input string tag);
    bit ei;
    int ea, el;
    model(ei, ea, el);
    chk(irq == ei, {tag, " irq"}, int'(irq), int'(ei));
    chk(int'(irq_addr) == ea, {tag, " addr"}, int'(irq_addr), ea);
    chk(int'(irq_lvl) == el, {tag, " lvl"}, int'(irq_lvl), el);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // R8 / R11: ack pulse, optional simultaneous reti (R9)
  task automatic do_ack(input bit with_reti, input string tag);
    bit was = irq;
    int lv = int'(irq_lvl);
    ack = 1'b1;
    reti = with_reti;
    settle();
    ack = 1'b0;
    reti = 1'b0;
    if (was && depth < 3) begin
      stk[depth] = lv;
      depth++;
    end
    chk(irq == 1'b0, {tag, " R8 gap"}, int'(irq), 0);
    chk(int'(cur_lvl) == exp_cur(), {tag, " cur"}, int'(cur_lvl), exp_cur());
    settle();
    check_out({tag, " after"});
  endtask

  // R9
  task automatic do_reti(input string tag);
    reti = 1'b1;
    settle();
    reti = 1'b0;
    if (depth > 0) depth--;
    chk(int'(cur_lvl) == exp_cur(), {tag, " R9 cur"}, int'(cur_lvl), exp_cur());
    settle();
    check_out({tag, " R10 after"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    src_pend = '0; src_en = '0; vec_hi = '0;
    glb_en = 1'b0; ack = 1'b0; reti = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // reset state
    chk(irq == 1'b0, "reset irq", int'(irq), 0);
    chk(irq_addr == 8'h00, "reset addr", int'(irq_addr), 0);
    chk(cur_lvl == 2'd0, "reset cur", int'(cur_lvl), 0);

    glb_en = 1'b1;
    // R1 R2 R3 R5: every source alone, both priority settings, enabled or not
    for (int s = 0; s < 21; s++) begin
      for (int h = 0; h < 2; h++) begin
        for (int e = 0; e < 2; e++) begin
          src_pend = 21'(1) << s;
          src_en = e ? 21'h1FFFFF : ~(21'(1) << s);
          vec_hi = h ? 10'h3FF : 10'h000;
          settle();
          check_out($sformatf("R1 R2 R3 R5 src%0d h%0d e%0d", s, h, e));
        end
      end
    end

    // R4 R6: all ordered vector pairs under four priority patterns
    src_en = 21'h1FFFFF;
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 10; a++) begin
        for (int b = 0; b < 10; b++) begin
          case (k)
            0: vec_hi = 10'h000;
            1: vec_hi = 10'h3FF;
            2: vec_hi = 10'h155;
            default: vec_hi = 10'h2AA;
          endcase
          src_pend = (21'(1) << first_src[a]) | (21'(1) << (first_src[b+1] - 1));
          settle();
          check_out($sformatf("R4 pair k%0d a%0d b%0d", k, a, b));
        end
      end
    end

    // R7: global enable low gates the request
    src_pend = 21'h1FFFFF;
    glb_en = 1'b0;
    settle();
    check_out("R7 gate off");
    glb_en = 1'b1;
    settle();
    check_out("R7 gate on");

    // nesting: vec5 low, vec3 high, vec4 high, vec0 top
    vec_hi = 10'b0000011001;
    src_pend = 21'(1) << first_src[5];
    settle();
    check_out("R6 low request");
    do_ack(1'b0, "ack low");            // cur 1, vec5 still pending, R10 not re-accepted
    do_ack(1'b0, "R11 stray ack");      // irq low: ignored
    src_pend = src_pend | (21'(1) << first_src[3]);
    settle();
    check_out("R6 high over low");
    do_ack(1'b0, "ack high");           // cur 2
    src_pend = src_pend | (21'(1) << first_src[4]);
    settle();
    check_out("R6 equal level held off");
    src_pend = src_pend | (21'(1) << first_src[0]);
    settle();
    check_out("R6 top over high");
    do_ack(1'b0, "ack top");            // cur 3
    do_ack(1'b0, "R11 stray ack full");
    do_reti("reti from top");           // cur 2, vec0 wins again
    do_ack(1'b1, "R9 ack with reti");   // push wins, reti ignored
    do_reti("reti two");
    do_reti("reti three");
    do_reti("reti four");
    do_reti("R9 reti empty");
    src_pend = '0;
    settle();
    check_out("R1 idle");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule